// File: doc/BRIEF.md
# GPIO Port Controller

This block is a 16-pin general-purpose I/O port. A 32-bit word register interface reaches it through a 0x400-byte window. Per-pin configuration is held as 2-bit mode, speed and pull fields, together with output type, alternate-function words, a lock word and an output data word. Every cycle the block resolves an observed level for each pin from three sources: an external driver, the port's own output, or its pull setting. The resolved levels are readable as the input data word.

A clock controller supplies an enable and a synchronous port reset. While the port is disabled the register interface is closed. A rising edge on the reset input restores the configuration, optionally to a per-port preset. Downstream logic can watch a per-pin relay of input-mode levels and a one-cycle pulse that marks each re-evaluation. A one-cycle error flag reports refused or unmapped accesses, and another reports a pin that is driven both by the port and from outside.

Top module: `gpio_port`

## Requirements
- R1: After `rst_ni` is released, every register reads 0, except the fields set by the selected preset. `pin_chg_o`, `acc_err_o` and `pin_clash_o` are 0.
- R2: The mode (0x00), output type (0x04), speed (0x08), pull (0x0C), output data (0x14), lock (0x1C), alternate low (0x20) and alternate high (0x24) words store a full 32-bit write, and the same offset reads it back. The read data is combinational in the request cycle.
- R3: A write to the set/clear word (0x18) first clears each output-data bit i for which write bit 16+i is 1, then sets each bit i for which write bit i is 1. Set therefore wins on the same pin. The word reads 0.
- R4: Input data bit i (0x10) becomes 1 or 0 in this order of priority. If `pin_drv_i[i]` is 1, it equals `pin_val_i[i]`. Otherwise, if mode bits [2i+1:2i] are 01 (output), it equals output-data bit i. Otherwise it is 1 exactly when pull bits [2i+1:2i] are 01 (pull-up). Mode 00 is input, 10 is alternate function and 11 is analog; pull 10 is pull-down. The new value is visible two clock edges after the causing stimulus.
- R5: `pin_chg_o[i]` takes the new input-data bit i when that bit changes while pin i is in mode 00, and it holds its value otherwise. `port_upd_o` is high for one cycle, two edges after each accepted write, pin input change, enable change or port reset edge. It is updated on the same edge as the input data.
- R6: While `port_en_i` is 0, reads return 0, writes have no effect and each access raises `acc_err_o`. A change of `port_en_i` causes a `port_upd_o` pulse.
- R7: A rising edge of `port_rst_i` restores every configuration and output word to its reset value. The enable is unaffected. Both edges cause a `port_upd_o` pulse.
- R8: With `PRESET` set to port A, the mode word resets to 0xA8000000 and the pull word to 0x64000000. With port B, the mode word resets to 0x00000280, speed to 0x000000C0 and pull to 0x00000100.
- R9: With `HAS_BRR`=1, a write to 0x28 clears the output-data bits set in write bits [15:0], and the word reads 0. With `HAS_BRR`=0, offset 0x28 is unmapped. Writes to the input data word are ignored without error.
- R10: `acc_err_o` is high for exactly one cycle after an access to an unaligned offset, to an offset above the last mapped word, or made while the port is disabled.
- R11: `pin_clash_o` is high for one cycle, together with `port_upd_o`, when after a re-evaluation some pin is both in mode 01 and externally driven. Such a pin reads the external value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one word per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| port_en_i | input | 1 | Port enable from the clock controller |
| port_rst_i | input | 1 | Synchronous port reset from the clock controller |
| pin_drv_i | input | NPIN | External driver present, per pin |
| pin_val_i | input | NPIN | External driven level, per pin |
| pin_chg_o | output | NPIN | Relayed level of input-mode pins |
| port_upd_o | output | 1 | One-cycle pulse after a re-evaluation |
| acc_err_o | output | 1 | One-cycle refused or unmapped access flag |
| pin_clash_o | output | 1 | One-cycle output/external contention flag |

## Verification
The assertions assume a bus master that holds `req_i`, `we_i`, `addr_i` and `wdata_i` steady across a clock edge and issues one access per request cycle. They also assume that `port_en_i`, `port_rst_i` and the pin inputs are synchronous to `clk_i`. The bench drives every input on the falling edge and lowers `req_i` after one rising edge. It leaves idle cycles between stimuli, so each re-evaluation and its pulses are seen in isolation before the next change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'd0,
    PM_OUT = 2'd1,
    PM_ALT = 2'd2,
    PM_ANA = 2'd3
  } pin_mode_e;

  localparam logic [1:0] PULL_UP = 2'd1;

  typedef enum logic [1:0] {
    RST_PLAIN  = 2'd0,
    RST_PORT_A = 2'd1,
    RST_PORT_B = 2'd2
  } rst_preset_e;

  // word indices (byte offset / 4)
  localparam logic [3:0] W_MODE  = 4'd0;
  localparam logic [3:0] W_OTYPE = 4'd1;
  localparam logic [3:0] W_SPEED = 4'd2;
  localparam logic [3:0] W_PULL  = 4'd3;
  localparam logic [3:0] W_IDR   = 4'd4;
  localparam logic [3:0] W_ODR   = 4'd5;
  localparam logic [3:0] W_SETCL = 4'd6;
  localparam logic [3:0] W_LOCK  = 4'd7;
  localparam logic [3:0] W_AFL   = 4'd8;
  localparam logic [3:0] W_AFH   = 4'd9;
  localparam logic [3:0] W_CLR   = 4'd10;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] otype;
    logic [31:0] speed;
    logic [31:0] pull;
    logic [31:0] odr;
    logic [31:0] lock;
    logic [31:0] afl;
    logic [31:0] afh;
  } port_cfg_t;

  function automatic port_cfg_t preset_cfg(rst_preset_e p);
    port_cfg_t c;
    c = '0;
    case (p)
      RST_PORT_A: begin
        c.mode = 32'hA800_0000;
        c.pull = 32'h6400_0000;
      end
      RST_PORT_B: begin
        c.mode  = 32'h0000_0280;
        c.speed = 32'h0000_00C0;
        c.pull  = 32'h0000_0100;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN    = 16,
  parameter int unsigned AW      = 10,
  parameter bit          HAS_BRR = 1'b1,
  parameter rst_preset_e PRESET  = RST_PLAIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            en_i,
  input  logic            rst_rise_i,
  input  logic [NPIN-1:0] idr_i,
  output logic [31:0]     rdata_o,
  output logic            wr_ok_o,
  output logic            bad_acc_o,
  output port_cfg_t       cfg_o
);

  localparam logic [31:0] PIN_MASK = 32'((64'd1 << NPIN) - 64'd1);
  localparam logic [3:0]  LAST_W   = HAS_BRR ? W_CLR : W_AFH;
  localparam port_cfg_t   RST_CFG  = preset_cfg(PRESET);

  port_cfg_t   cfg_q;
  logic [3:0]  word;
  logic        hit;
  logic [31:0] set_m, clr_m;

  assign word  = addr_i[5:2];
  assign hit   = (addr_i[1:0] == 2'b00) && (addr_i[AW-1:6] == '0) && (word <= LAST_W);
  assign set_m = wdata_i & PIN_MASK;
  assign clr_m = (wdata_i >> 16) & PIN_MASK;

  assign wr_ok_o   = req_i && we_i && en_i && hit;
  assign bad_acc_o = req_i && (!en_i || !hit);
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RST_CFG;
    end else if (rst_rise_i) begin
      cfg_q <= RST_CFG;
    end else if (wr_ok_o) begin
      case (word)
        W_MODE:  cfg_q.mode  <= wdata_i;
        W_OTYPE: cfg_q.otype <= wdata_i;
        W_SPEED: cfg_q.speed <= wdata_i;
        W_PULL:  cfg_q.pull  <= wdata_i;
        W_ODR:   cfg_q.odr   <= wdata_i;
        W_SETCL: cfg_q.odr   <= (cfg_q.odr & ~clr_m) | set_m;
        W_LOCK:  cfg_q.lock  <= wdata_i;
        W_AFL:   cfg_q.afl   <= wdata_i;
        W_AFH:   cfg_q.afh   <= wdata_i;
        W_CLR:   cfg_q.odr   <= cfg_q.odr & ~set_m;
        default: ;  // input data word is read-only
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && en_i && hit) begin
      case (word)
        W_MODE:  rdata_o = cfg_q.mode;
        W_OTYPE: rdata_o = cfg_q.otype;
        W_SPEED: rdata_o = cfg_q.speed;
        W_PULL:  rdata_o = cfg_q.pull;
        W_IDR:   rdata_o = 32'(idr_i);
        W_ODR:   rdata_o = cfg_q.odr;
        W_LOCK:  rdata_o = cfg_q.lock;
        W_AFL:   rdata_o = cfg_q.afl;
        W_AFH:   rdata_o = cfg_q.afh;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && word == W_SETCL && !rst_rise_i) |=>
      (((cfg_q.odr & $past(set_m)) == $past(set_m)) &&
       ((cfg_q.odr & $past(clr_m & ~set_m)) == 32'd0)));

  assert_off_write_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !en_i && !rst_rise_i) |=> ($stable(cfg_q.odr) && $stable(cfg_q.mode)));

  assert_port_rst_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_rise_i |=> (cfg_q.odr == 32'd0 && cfg_q.lock == 32'd0));

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic [2*NPIN-1:0] mode_i,
  input  logic [2*NPIN-1:0] pull_i,
  input  logic [NPIN-1:0]   odr_i,
  input  logic [NPIN-1:0]   drv_i,
  input  logic [NPIN-1:0]   val_i,
  output logic [NPIN-1:0]   lvl_o,
  output logic [NPIN-1:0]   in_mode_o,
  output logic [NPIN-1:0]   clash_o
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] m, p;
    logic       is_out;
    assign m      = mode_i[2*i +: 2];
    assign p      = pull_i[2*i +: 2];
    assign is_out = (m == PM_OUT);

    // external driver > own output > pull-up
    assign lvl_o[i]     = drv_i[i] ? val_i[i] : (is_out ? odr_i[i] : (p == PULL_UP));
    assign in_mode_o[i] = (m == PM_IN);
    assign clash_o[i]   = drv_i[i] && is_out;
  end

endmodule

// File: rtl/gpio_port_evt.sv
module gpio_port_evt #(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            port_rst_i,
  input  logic [NPIN-1:0] drv_i,
  input  logic [NPIN-1:0] val_i,
  input  logic            wr_ok_i,
  input  logic            bad_acc_i,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] in_mode_i,
  input  logic [NPIN-1:0] clash_i,
  output logic [NPIN-1:0] drv_q_o,
  output logic [NPIN-1:0] val_q_o,
  output logic            rst_rise_o,
  output logic [NPIN-1:0] idr_o,
  output logic [NPIN-1:0] relay_o,
  output logic            upd_o,
  output logic            acc_err_o,
  output logic            clash_o
);

  logic            en_q, prst_q, trig, trig_q, upd_q, err_q, clash_q;
  logic [NPIN-1:0] drv_q, val_q, idr_q, relay_q;

  assign rst_rise_o = port_rst_i && !prst_q;
  assign trig = wr_ok_i || (port_rst_i != prst_q) || (en_i != en_q) ||
                (drv_i != drv_q) || (val_i != val_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      prst_q  <= 1'b0;
      drv_q   <= '0;
      val_q   <= '0;
      trig_q  <= 1'b1;  // evaluate once after reset
      upd_q   <= 1'b0;
      err_q   <= 1'b0;
      clash_q <= 1'b0;
      idr_q   <= '0;
    end else begin
      en_q    <= en_i;
      prst_q  <= port_rst_i;
      drv_q   <= drv_i;
      val_q   <= val_i;
      trig_q  <= trig;
      upd_q   <= trig_q;
      err_q   <= bad_acc_i;
      clash_q <= trig_q && (|clash_i);
      idr_q   <= lvl_i;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_relay
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     relay_q[i] <= 1'b0;
      else if (in_mode_i[i] && (lvl_i[i] != idr_q[i])) relay_q[i] <= lvl_i[i];
    end
  end

  assign drv_q_o   = drv_q;
  assign val_q_o   = val_q;
  assign idr_o     = idr_q;
  assign relay_o   = relay_q;
  assign upd_o     = upd_q;
  assign acc_err_o = err_q;
  assign clash_o   = clash_q;

  assert_relay_input_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((relay_q ^ $past(relay_q)) & ~$past(in_mode_i)) == '0);

  assert_clash_with_upd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_q |-> upd_q);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN    = 16,
  parameter int unsigned AW      = 10,
  parameter bit          HAS_BRR = 1'b1,
  parameter rst_preset_e PRESET  = RST_PLAIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic            port_en_i,
  input  logic            port_rst_i,
  input  logic [NPIN-1:0] pin_drv_i,
  input  logic [NPIN-1:0] pin_val_i,
  output logic [NPIN-1:0] pin_chg_o,
  output logic            port_upd_o,
  output logic            acc_err_o,
  output logic            pin_clash_o
);

  port_cfg_t       cfg;
  logic            wr_ok, bad_acc, rst_rise;
  logic [NPIN-1:0] drv_q, val_q, lvl, in_mode, clash, idr;

  gpio_port_regs #(
    .NPIN(NPIN), .AW(AW), .HAS_BRR(HAS_BRR), .PRESET(PRESET)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .en_i       (port_en_i),
    .rst_rise_i (rst_rise),
    .idr_i      (idr),
    .rdata_o    (rdata_o),
    .wr_ok_o    (wr_ok),
    .bad_acc_o  (bad_acc),
    .cfg_o      (cfg)
  );

  gpio_pin_resolve #(.NPIN(NPIN)) u_resolve (
    .mode_i    (cfg.mode[2*NPIN-1:0]),
    .pull_i    (cfg.pull[2*NPIN-1:0]),
    .odr_i     (cfg.odr[NPIN-1:0]),
    .drv_i     (drv_q),
    .val_i     (val_q),
    .lvl_o     (lvl),
    .in_mode_o (in_mode),
    .clash_o   (clash)
  );

  gpio_port_evt #(.NPIN(NPIN)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (port_en_i),
    .port_rst_i (port_rst_i),
    .drv_i      (pin_drv_i),
    .val_i      (pin_val_i),
    .wr_ok_i    (wr_ok),
    .bad_acc_i  (bad_acc),
    .lvl_i      (lvl),
    .in_mode_i  (in_mode),
    .clash_i    (clash),
    .drv_q_o    (drv_q),
    .val_q_o    (val_q),
    .rst_rise_o (rst_rise),
    .idr_o      (idr),
    .relay_o    (pin_chg_o),
    .upd_o      (port_upd_o),
    .acc_err_o  (acc_err_o),
    .clash_o    (pin_clash_o)
  );

  assert_upd_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> ##1 port_upd_o);

  assert_off_read_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !port_en_i) |=> acc_err_o);

endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  import gpio_port_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        port_en = 1'b1, port_rst = 1'b0;
  logic [15:0] pin_drv = '0, pin_val = '0;

  logic [31:0] rdata_a, rdata_b;
  logic [15:0] chg_a, chg_b;
  logic        upd_a, upd_b, err_a, err_b, clash_a, clash_b;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [31:0] rd_a, rd_b;
  logic        l_err_a, l_err_b, l_err_next, l_upd, l_upd2, l_clash;
  logic [15:0] l_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .port_en_i(port_en), .port_rst_i(port_rst),
    .pin_drv_i(pin_drv), .pin_val_i(pin_val), .pin_chg_o(chg_a),
    .port_upd_o(upd_a), .acc_err_o(err_a), .pin_clash_o(clash_a)
  );

  gpio_port #(.HAS_BRR(1'b0), .PRESET(RST_PORT_A)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .port_en_i(port_en), .port_rst_i(port_rst),
    .pin_drv_i(pin_drv), .pin_val_i(pin_val), .pin_chg_o(chg_b),
    .port_upd_o(upd_b), .acc_err_o(err_b), .pin_clash_o(clash_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic bus_rd(input logic [9:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1; rd_a = rdata_a; rd_b = rdata_b;
    @(negedge clk); l_err_a = err_a; l_err_b = err_b; req = 1'b0;
    @(negedge clk); l_err_next = err_a;
  endtask

  task automatic settle();
    @(negedge clk); l_err_a = err_a; l_err_b = err_b; req = 1'b0; we = 1'b0;
    @(negedge clk); l_upd = upd_a; l_clash = clash_a; l_chg = chg_a;
    @(negedge clk); l_upd2 = upd_a;
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    settle();
  endtask

  task automatic set_pins(input logic [15:0] drv, input logic [15:0] val);
    @(negedge clk); pin_drv = drv; pin_val = val;
    settle();
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); port_en = v;
    settle();
  endtask

  task automatic set_prst(input logic v);
    @(negedge clk); port_rst = v;
    settle();
  endtask

  task automatic t_reset();
    bus_rd(10'h000); chk_eq("R1 mode after reset", rd_a, 32'h0);
    chk_eq("R8 preset A mode", rd_b, 32'hA800_0000);
    bus_rd(10'h00C); chk_eq("R8 preset A pull", rd_b, 32'h6400_0000);
    bus_rd(10'h014); chk_eq("R1 odr after reset", rd_a, 32'h0);
    bus_rd(10'h010); chk_eq("R1 idr after reset", rd_a, 32'h0);
    chk_eq("R4 preset A idr pull-ups on alt pins", rd_b, 32'h0000_A000);
    chk_eq("R1 chg after reset", 32'(chg_a), 32'h0);
    chk_eq("R1 err after reset", 32'(l_err_a), 32'h0);
    chk_eq("R1 clash after reset", 32'(clash_a), 32'h0);
  endtask

  task automatic t_brr_variant();
    bus_wr(10'h028, 32'h0000_0001);
    chk_eq("R9 clear word mapped when present", 32'(l_err_a), 32'h0);
    chk_eq("R9 clear word unmapped when absent", 32'(l_err_b), 32'h1);
  endtask

  task automatic t_storage();
    bus_wr(10'h008, 32'hDEAD_BEEF); bus_rd(10'h008); chk_eq("R2 speed round trip", rd_a, 32'hDEAD_BEEF);
    bus_wr(10'h004, 32'h0000_A5A5); bus_rd(10'h004); chk_eq("R2 otype round trip", rd_a, 32'h0000_A5A5);
    bus_wr(10'h01C, 32'h0001_0005); bus_rd(10'h01C); chk_eq("R2 lock plain storage", rd_a, 32'h0001_0005);
    bus_wr(10'h024, 32'h1234_5678); bus_rd(10'h024); chk_eq("R2 alt high round trip", rd_a, 32'h1234_5678);
  endtask

  task automatic t_setclr();
    bus_wr(10'h014, 32'h0000_00F0);
    bus_wr(10'h018, 32'h0011_0001);
    bus_rd(10'h014); chk_eq("R3 clear then set, set wins", rd_a, 32'h0000_00E1);
    bus_rd(10'h018); chk_eq("R3 set/clear word reads 0", rd_a, 32'h0);
  endtask

  task automatic t_brr();
    bus_wr(10'h028, 32'h0000_0041);
    bus_rd(10'h014); chk_eq("R9 clear word clears odr bits", rd_a, 32'h0000_00A0);
    bus_rd(10'h028); chk_eq("R9 clear word reads 0", rd_a, 32'h0);
    bus_wr(10'h010, 32'h0000_FFFF);
    chk_eq("R9 idr write no error", 32'(l_err_a), 32'h0);
    bus_rd(10'h010); chk_eq("R9 idr write ignored", rd_a, 32'h0);
  endtask

  task automatic t_resolve();
    bus_wr(10'h014, 32'h0000_02A0);
    bus_wr(10'h000, 32'h0008_8400);
    bus_wr(10'h00C, 32'h0000_6040);
    chk_eq("R5 upd two edges after write", 32'(l_upd), 32'h1);
    chk_eq("R5 upd lasts one cycle", 32'(l_upd2), 32'h0);
    chk_eq("R5 chg only for input-mode pin", 32'(l_chg), 32'h0000_0008);
    bus_rd(10'h010); chk_eq("R4 priority by mode and pull", rd_a, 32'h0000_00A8);
    set_pins(16'h0060, 16'h0040);
    chk_eq("R11 clash pulse", 32'(l_clash), 32'h1);
    chk_eq("R5 upd on pin input change", 32'(l_upd), 32'h1);
    chk_eq("R5 chg follows driven input pin", 32'(l_chg), 32'h0000_0048);
    bus_rd(10'h010); chk_eq("R4 R11 external driver wins", rd_a, 32'h0000_00C8);
    set_pins(16'h0000, 16'h0000);
    chk_eq("R11 no clash after release", 32'(l_clash), 32'h0);
    chk_eq("R5 chg drops with pull-down", 32'(l_chg), 32'h0000_0008);
    bus_rd(10'h010); chk_eq("R4 idr after release", rd_a, 32'h0000_00A8);
  endtask

  task automatic t_disabled();
    set_en(1'b0);
    chk_eq("R6 upd on enable change", 32'(l_upd), 32'h1);
    bus_rd(10'h014);
    chk_eq("R6 read while off is 0", rd_a, 32'h0);
    chk_eq("R6 read while off errors", 32'(l_err_a), 32'h1);
    bus_wr(10'h014, 32'h0000_FFFF);
    chk_eq("R6 write while off errors", 32'(l_err_a), 32'h1);
    chk_eq("R6 ignored write gives no upd", 32'(l_upd), 32'h0);
    set_en(1'b1);
    bus_rd(10'h014); chk_eq("R6 odr kept across off write", rd_a, 32'h0000_02A0);
  endtask

  task automatic t_port_rst();
    set_prst(1'b1);
    chk_eq("R7 upd on reset rise", 32'(l_upd), 32'h1);
    chk_eq("R7 chg follows cleared pull", 32'(l_chg), 32'h0);
    set_prst(1'b0);
    chk_eq("R7 upd on reset fall", 32'(l_upd), 32'h1);
    bus_rd(10'h000); chk_eq("R7 mode cleared", rd_a, 32'h0);
    chk_eq("R7 enable kept, no error", 32'(l_err_a), 32'h0);
    chk_eq("R8 preset restored by port reset", rd_b, 32'hA800_0000);
    bus_rd(10'h014); chk_eq("R7 odr cleared", rd_a, 32'h0);
    bus_rd(10'h01C); chk_eq("R7 lock cleared", rd_a, 32'h0);
    bus_rd(10'h010); chk_eq("R7 idr re-evaluated", rd_a, 32'h0);
  endtask

  task automatic t_bad_offset();
    bus_rd(10'h02C); chk_eq("R10 offset past map", 32'(l_err_a), 32'h1);
    chk_eq("R10 error one cycle", 32'(l_err_next), 32'h0);
    bus_rd(10'h006); chk_eq("R10 unaligned offset", 32'(l_err_a), 32'h1);
    bus_rd(10'h3FC); chk_eq("R10 top of window", 32'(l_err_a), 32'h1);
    bus_rd(10'h024); chk_eq("R10 mapped offset no error", 32'(l_err_a), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_brr_variant();
    t_storage();
    t_setclr();
    t_brr();
    t_resolve();
    t_disabled();
    t_port_rst();
    t_bad_offset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0x%08h exp=0x%08h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule